// File: doc/BRIEF.md
# Operand Effective-Address Sequencer

This block turns an addressing mode, a program counter and two index registers into a single effective address for an 8-bit style processor core. When `start` is pulsed it captures its inputs, walks through the memory reads that the mode needs over a byte-wide read port with one cycle of latency, and pulses `done`. With `done` it presents the effective address and the number of operand bytes that follow the opcode, so the core can advance its program counter.

The read sequence depends on the mode. Absolute and indirect forms fetch a little-endian operand. Pointer forms read a second pair of bytes. Zero-page forms keep every sum and every pointer byte inside page zero. Indexed indirect adds X before it follows the pointer. Indirect indexed follows the pointer first and then adds Y. Reading the operand value at the effective address is left to the core.

The data width `DW` is a parameter, and the address is `2*DW` bits wide. In the default build bytes are 8 bits and addresses are 16 bits.

Top module: `operand_addr_unit`

## Requirements
- R1: While reset is active and in the first cycle after it, `done` and `rd_en` are low.
- R2: Mode codes 0 and 11 to 15 are implied or accumulator. `done` rises in the cycle after the accepted start, with `eff_addr` = 0 and `opnd_len` = 0. No read is issued.
- R3: Mode 1 is immediate. `done` rises in the cycle after start, with `eff_addr` = PC+1 (modulo 2^(2·DW)) and `opnd_len` = 1. No read is issued.
- R4: Mode 2 is zero page. The block makes one read at PC+1, and `eff_addr` = {0, that byte}. `opnd_len` = 1, and `done` rises 3 cycles after start.
- R5: Mode 3 (X) and mode 4 (Y) are zero page indexed. `eff_addr` = {0, (byte + index) mod 2^DW}, so the upper half is always zero. Otherwise they behave as R4.
- R6: Mode 5 is absolute. The low byte is read at PC+1 and the high byte at PC+2, and `eff_addr` = {high, low}. `opnd_len` = 2. There are 2 reads, and `done` rises 4 cycles after start.
- R7: Mode 6 (X) and mode 7 (Y) are absolute indexed. They add the index to the R6 address modulo 2^(2·DW). Otherwise they behave as R6.
- R8: Mode 8 is indirect. The pointer P is assembled as in R6. The low result byte is read at P and the high byte at P+1 (full-width carry). `opnd_len` = 2. There are 4 reads, and `done` rises 6 cycles after start.
- R9: Mode 9 is indexed indirect. Z = (byte at PC+1 + X) mod 2^DW. The low result byte comes from {0,Z} and the high byte from {0,(Z+1) mod 2^DW}. `opnd_len` = 1. There are 3 reads, and `done` rises 5 cycles after start.
- R10: Mode 10 is indirect indexed. B is the byte at PC+1. The pointer is read from {0,B} (low) and {0,(B+1) mod 2^DW} (high), and Y is then added modulo 2^(2·DW). `opnd_len` = 1. There are 3 reads, and `done` rises 5 cycles after start.
- R11: Each accepted start gives exactly one single-cycle `done`. A `start` while busy is ignored, and the result is that of the captured inputs even when the inputs change afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a computation (accepted only when idle) |
| mode | input | 4 | Addressing-mode code (see R2 to R10) |
| pc | input | 2*DW | Address of the opcode |
| idx_x | input | DW | X index register |
| idx_y | input | DW | Y index register |
| rd_en | output | 1 | Read request this cycle |
| rd_addr | output | 2*DW | Read address |
| rd_data | input | DW | Read data, valid the cycle after the request |
| done | output | 1 | One-cycle completion strobe |
| eff_addr | output | 2*DW | Effective address, valid with `done` |
| opnd_len | output | 2 | Operand bytes after the opcode, valid with `done` |

## Verification
The bench builds the block with `DW` = 4, which gives 8-bit addresses and a 16-entry zero page. At this size it can sweep all sixteen mode codes against every X value and several program-counter positions. These include the last two addresses of the space, where PC+1 and PC+2 roll over. The small page means that every zero-page sum, and every pointer that sits at the page's top byte, wraps many times across the sweep. Memory contents come from an arithmetic function of the address, so the bench can derive every expected address itself.

// File: rtl/oau_pkg.sv
package oau_pkg;

   localparam logic [3:0] AM_IMPL = 4'd0;
   localparam logic [3:0] AM_IMM  = 4'd1;
   localparam logic [3:0] AM_ZP   = 4'd2;
   localparam logic [3:0] AM_ZPX  = 4'd3;
   localparam logic [3:0] AM_ZPY  = 4'd4;
   localparam logic [3:0] AM_ABS  = 4'd5;
   localparam logic [3:0] AM_ABSX = 4'd6;
   localparam logic [3:0] AM_ABSY = 4'd7;
   localparam logic [3:0] AM_IND  = 4'd8;
   localparam logic [3:0] AM_XIND = 4'd9;
   localparam logic [3:0] AM_INDY = 4'd10;

   typedef enum logic [1:0] {
      IX_NONE = 2'd0,
      IX_X    = 2'd1,
      IX_Y    = 2'd2
   } idx_sel_e;

   // Per-mode attributes driven by the decoder
   typedef struct packed {
      logic [1:0] nbytes;     // operand bytes following the opcode
      logic       no_read;    // completes without touching memory
      logic       two_op;     // operand is two bytes
      logic       ptr;        // a pointer pair is dereferenced
      logic       ptr_zp;     // pointer lives in page zero
      logic       pre_x;      // X is added before dereference
      logic       zp_result;  // result stays inside page zero
      idx_sel_e   idx;        // index added to the final address
   } am_attr_t;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_OPLO  = 3'd1,
      ST_OPHI  = 3'd2,
      ST_PTRLO = 3'd3,
      ST_PTRHI = 3'd4,
      ST_LAST  = 3'd5
   } st_e;

endpackage

// File: rtl/oau_decode.sv
module oau_decode
   import oau_pkg::*;
(
   input  logic [3:0] mode,
   output am_attr_t   attr
);

   always_comb begin
      attr     = '0;
      attr.idx = IX_NONE;
      case (mode)
         AM_IMM: begin
            attr.nbytes  = 2'd1;
            attr.no_read = 1'b1;
         end
         AM_ZP, AM_ZPX, AM_ZPY: begin
            attr.nbytes    = 2'd1;
            attr.zp_result = 1'b1;
            attr.idx       = (mode == AM_ZPX) ? IX_X :
                             (mode == AM_ZPY) ? IX_Y : IX_NONE;
         end
         AM_ABS, AM_ABSX, AM_ABSY: begin
            attr.nbytes = 2'd2;
            attr.two_op = 1'b1;
            attr.idx    = (mode == AM_ABSX) ? IX_X :
                          (mode == AM_ABSY) ? IX_Y : IX_NONE;
         end
         AM_IND: begin
            attr.nbytes = 2'd2;
            attr.two_op = 1'b1;
            attr.ptr    = 1'b1;
         end
         AM_XIND: begin
            attr.nbytes = 2'd1;
            attr.ptr    = 1'b1;
            attr.ptr_zp = 1'b1;
            attr.pre_x  = 1'b1;
         end
         AM_INDY: begin
            attr.nbytes = 2'd1;
            attr.ptr    = 1'b1;
            attr.ptr_zp = 1'b1;
            attr.idx    = IX_Y;
         end
         default: begin
            // implied, accumulator and all unassigned codes
            attr.nbytes  = 2'd0;
            attr.no_read = 1'b1;
         end
      endcase
   end

endmodule

// File: rtl/oau_addr_calc.sv
module oau_addr_calc
   import oau_pkg::*;
#(
   parameter int DW = 8,
   localparam int AW = 2 * DW
)(
   input  logic          a_ptr_zp,
   input  logic          a_pre_x,
   input  logic          a_zp_result,
   input  idx_sel_e      a_idx,
   input  logic [DW-1:0] x_q,
   input  logic [DW-1:0] y_q,
   input  logic [DW-1:0] lo_q,
   input  logic [AW-1:0] ptr_q,
   input  logic [DW-1:0] rd_data,
   output logic [AW-1:0] ptr_next,
   output logic [AW-1:0] ptr_inc,
   output logic [AW-1:0] final_ea
);

   localparam logic [DW-1:0] ZERO_HI = '0;

   logic [DW-1:0] idx_val;
   logic [DW-1:0] zp_ptr;
   logic [DW-1:0] zp_ptr_inc;
   logic [DW-1:0] zp_res;
   logic [AW-1:0] pair;

   always_comb begin
      case (a_idx)
         IX_X:    idx_val = x_q;
         IX_Y:    idx_val = y_q;
         default: idx_val = '0;
      endcase
   end

   // Byte-wide sums wrap inside page zero
   assign zp_ptr     = rd_data + (a_pre_x ? x_q : ZERO_HI);
   assign zp_ptr_inc = ptr_q[DW-1:0] + DW'(1);
   assign zp_res     = rd_data + idx_val;

   // Little-endian pair: newest byte is the high half
   assign pair = {rd_data, lo_q};

   assign ptr_next = a_ptr_zp ? {ZERO_HI, zp_ptr} : pair;
   assign ptr_inc  = a_ptr_zp ? {ZERO_HI, zp_ptr_inc} : ptr_q + AW'(1);
   assign final_ea = a_zp_result ? {ZERO_HI, zp_res}
                                 : pair + {ZERO_HI, idx_val};

endmodule

// File: rtl/oau_seq.sv
module oau_seq
   import oau_pkg::*;
#(
   parameter int DW = 8,
   localparam int AW = 2 * DW
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [3:0]    mode,
   input  logic [AW-1:0] pc,
   input  logic [DW-1:0] idx_x,
   input  logic [DW-1:0] idx_y,
   input  logic [DW-1:0] rd_data,
   // attributes of mode_sel
   input  logic [1:0]    a_nbytes,
   input  logic          a_no_read,
   input  logic          a_two_op,
   input  logic          a_ptr,
   input  logic          a_ptr_zp,
   input  logic          a_zp_result,
   // from the address calculator
   input  logic [AW-1:0] ptr_next,
   input  logic [AW-1:0] ptr_inc,
   input  logic [AW-1:0] final_ea,
   output logic [3:0]    mode_sel,
   output logic [DW-1:0] x_q,
   output logic [DW-1:0] y_q,
   output logic [DW-1:0] lo_q,
   output logic [AW-1:0] ptr_q,
   output logic          rd_en,
   output logic [AW-1:0] rd_addr,
   output logic          done,
   output logic [AW-1:0] eff_addr,
   output logic [1:0]    opnd_len
);

   st_e           state;
   logic [3:0]    mode_q;
   logic [AW-1:0] pc_q;
   logic          done_q;
   logic [AW-1:0] ea_q;
   logic [1:0]    len_q;

   // Live mode is decoded while idle, the captured one afterwards
   assign mode_sel = (state == ST_IDLE) ? mode : mode_q;

   always_comb begin
      rd_en   = 1'b1;
      rd_addr = '0;
      case (state)
         ST_OPLO:  rd_addr = pc_q + AW'(1);
         ST_OPHI:  rd_addr = pc_q + AW'(2);
         ST_PTRLO: rd_addr = ptr_next;
         ST_PTRHI: rd_addr = ptr_inc;
         default:  rd_en   = 1'b0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         mode_q <= '0;
         pc_q   <= '0;
         x_q    <= '0;
         y_q    <= '0;
         lo_q   <= '0;
         ptr_q  <= '0;
         done_q <= 1'b0;
         ea_q   <= '0;
         len_q  <= '0;
      end else begin
         done_q <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (start) begin
                  mode_q <= mode;
                  pc_q   <= pc;
                  x_q    <= idx_x;
                  y_q    <= idx_y;
                  if (a_no_read) begin
                     done_q <= 1'b1;
                     len_q  <= a_nbytes;
                     ea_q   <= (a_nbytes != 2'd0) ? pc + AW'(1) : '0;
                  end else begin
                     state <= ST_OPLO;
                  end
               end
            end
            ST_OPLO: begin
               state <= a_two_op ? ST_OPHI : (a_ptr ? ST_PTRLO : ST_LAST);
            end
            ST_OPHI: begin
               lo_q  <= rd_data;
               state <= a_ptr ? ST_PTRLO : ST_LAST;
            end
            ST_PTRLO: begin
               ptr_q <= ptr_next;
               state <= ST_PTRHI;
            end
            ST_PTRHI: begin
               lo_q  <= rd_data;
               state <= ST_LAST;
            end
            ST_LAST: begin
               ea_q   <= final_ea;
               len_q  <= a_nbytes;
               done_q <= 1'b1;
               state  <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign done     = done_q;
   assign eff_addr = ea_q;
   assign opnd_len = len_q;

   // Memory-free modes complete in the very next cycle
   assert_noread_next_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (start && state == ST_IDLE && a_no_read) |=> (done && !rd_en));

   // A start while busy leaves the captured operation untouched
   assert_busy_ignore_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (start && state != ST_IDLE) |=> ($stable(mode_q) && $stable(pc_q)));

   // A second done cycle only follows a fresh start
   assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!done || $past(start)));

   // Zero-page results never leave page zero
   assert_zp_page_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_LAST && a_zp_result) |=> (eff_addr[AW-1:DW] == '0));

   // Zero-page pointer reads stay inside page zero
   assert_ptr_page_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && a_ptr_zp && (state == ST_PTRLO || state == ST_PTRHI))
         |-> (rd_addr[AW-1:DW] == '0));

   assert_len_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (opnd_len <= 2'd2));

endmodule

// File: rtl/operand_addr_unit.sv
module operand_addr_unit
   import oau_pkg::*;
#(
   parameter int DW = 8
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [3:0]        mode,
   input  logic [2*DW-1:0]   pc,
   input  logic [DW-1:0]     idx_x,
   input  logic [DW-1:0]     idx_y,
   output logic              rd_en,
   output logic [2*DW-1:0]   rd_addr,
   input  logic [DW-1:0]     rd_data,
   output logic              done,
   output logic [2*DW-1:0]   eff_addr,
   output logic [1:0]        opnd_len
);

   localparam int AW = 2 * DW;

   generate
      if (DW < 2 || DW > 16) begin : g_bad_width
         $error("operand_addr_unit: DW must be between 2 and 16");
      end
   endgenerate

   logic [3:0]    mode_sel;
   am_attr_t      attr;
   logic [DW-1:0] x_q;
   logic [DW-1:0] y_q;
   logic [DW-1:0] lo_q;
   logic [AW-1:0] ptr_q;
   logic [AW-1:0] ptr_next;
   logic [AW-1:0] ptr_inc;
   logic [AW-1:0] final_ea;

   oau_decode u_decode (
      .mode (mode_sel),
      .attr (attr)
   );

   oau_addr_calc #(.DW(DW)) u_calc (
      .a_ptr_zp    (attr.ptr_zp),
      .a_pre_x     (attr.pre_x),
      .a_zp_result (attr.zp_result),
      .a_idx       (attr.idx),
      .x_q         (x_q),
      .y_q         (y_q),
      .lo_q        (lo_q),
      .ptr_q       (ptr_q),
      .rd_data     (rd_data),
      .ptr_next    (ptr_next),
      .ptr_inc     (ptr_inc),
      .final_ea    (final_ea)
   );

   oau_seq #(.DW(DW)) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (start),
      .mode        (mode),
      .pc          (pc),
      .idx_x       (idx_x),
      .idx_y       (idx_y),
      .rd_data     (rd_data),
      .a_nbytes    (attr.nbytes),
      .a_no_read   (attr.no_read),
      .a_two_op    (attr.two_op),
      .a_ptr       (attr.ptr),
      .a_ptr_zp    (attr.ptr_zp),
      .a_zp_result (attr.zp_result),
      .ptr_next    (ptr_next),
      .ptr_inc     (ptr_inc),
      .final_ea    (final_ea),
      .mode_sel    (mode_sel),
      .x_q         (x_q),
      .y_q         (y_q),
      .lo_q        (lo_q),
      .ptr_q       (ptr_q),
      .rd_en       (rd_en),
      .rd_addr     (rd_addr),
      .done        (done),
      .eff_addr    (eff_addr),
      .opnd_len    (opnd_len)
   );

endmodule

// File: tb/operand_addr_unit_test.sv
module operand_addr_unit_test;

   localparam int DW = 4;
   localparam int AW = 2 * DW;
   localparam int PG = 1 << DW;
   localparam int AS = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [3:0]    mode = '0;
   logic [AW-1:0] pc = '0;
   logic [DW-1:0] idx_x = '0;
   logic [DW-1:0] idx_y = '0;
   logic          rd_en;
   logic [AW-1:0] rd_addr;
   logic [DW-1:0] rd_data = '0;
   logic          done;
   logic [AW-1:0] eff_addr;
   logic [1:0]    opnd_len;

   int n_checks = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   operand_addr_unit #(.DW(DW)) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .pc(pc),
      .idx_x(idx_x), .idx_y(idx_y), .rd_en(rd_en), .rd_addr(rd_addr),
      .rd_data(rd_data), .done(done), .eff_addr(eff_addr), .opnd_len(opnd_len)
   );

   // Memory contents are a fixed function of the address
   function automatic int memf(input int a);
      int v;
      v = a % AS;
      return ((v * 7 + 5) ^ (v >> 3)) % PG;
   endfunction

   // One-cycle read latency
   always @(posedge clk) rd_data <= DW'(memf(int'(rd_addr)));

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   endtask

   task automatic run_op(input int m, input int p, input int x, input int y);
      int e_ea, e_len, e_lat, e_rd;
      int b1, b2, ptr, z;
      int k, rds;
      bit got;
      string tag;
      b1 = memf((p + 1) % AS);
      b2 = memf((p + 2) % AS);
      case (m)
         1: begin tag = "R3"; e_ea = (p + 1) % AS; e_len = 1; e_lat = 1; e_rd = 0; end
         2: begin tag = "R4"; e_ea = b1; e_len = 1; e_lat = 3; e_rd = 1; end
         3: begin tag = "R5"; e_ea = (b1 + x) % PG; e_len = 1; e_lat = 3; e_rd = 1; end
         4: begin tag = "R5"; e_ea = (b1 + y) % PG; e_len = 1; e_lat = 3; e_rd = 1; end
         5: begin tag = "R6"; e_ea = b2 * PG + b1; e_len = 2; e_lat = 4; e_rd = 2; end
         6: begin tag = "R7"; e_ea = (b2 * PG + b1 + x) % AS; e_len = 2; e_lat = 4; e_rd = 2; end
         7: begin tag = "R7"; e_ea = (b2 * PG + b1 + y) % AS; e_len = 2; e_lat = 4; e_rd = 2; end
         8: begin
            tag = "R8"; ptr = b2 * PG + b1;
            e_ea = memf(ptr) + PG * memf((ptr + 1) % AS);
            e_len = 2; e_lat = 6; e_rd = 4;
         end
         9: begin
            tag = "R9"; z = (b1 + x) % PG;
            e_ea = memf(z) + PG * memf((z + 1) % PG);
            e_len = 1; e_lat = 5; e_rd = 3;
         end
         10: begin
            tag = "R10";
            e_ea = (memf(b1) + PG * memf((b1 + 1) % PG) + y) % AS;
            e_len = 1; e_lat = 5; e_rd = 3;
         end
         default: begin tag = "R2"; e_ea = 0; e_len = 0; e_lat = 1; e_rd = 0; end
      endcase
      @(negedge clk);
      start = 1'b1; mode = 4'(m); pc = AW'(p); idx_x = DW'(x); idx_y = DW'(y);
      k = 0; rds = 0; got = 1'b0;
      while (k < 10 && !got) begin
         @(negedge clk);
         start = 1'b0;
         k++;
         if (done) got = 1'b1;
         else if (rd_en) rds++;
      end
      check(k == e_lat, {tag, " latency"}, k, e_lat);
      check(int'(eff_addr) == e_ea, {tag, " address"}, int'(eff_addr), e_ea);
      check(int'(opnd_len) == e_len, {tag, " length"}, int'(opnd_len), e_len);
      check(rds == e_rd, {tag, " reads"}, rds, e_rd);
      @(negedge clk);
      check(!done, "R11 single-cycle done", int'(done), 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      check(!done && !rd_en, "R1 during reset", int'({done, rd_en}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!done && !rd_en, "R1 after reset", int'({done, rd_en}), 0);

      // Sweep all mode codes, every X value, edge program counters
      for (int m = 0; m < 16; m++) begin
         for (int pi = 0; pi < 4; pi++) begin
            for (int x = 0; x < PG; x++) begin
               int p;
               p = (pi == 0) ? 0 : (pi == 1) ? 8'h37 : (pi == 2) ? AS - 2 : AS - 1;
               run_op(m, p, x, (x * 3 + 1) % PG);
            end
         end
      end

      // R11: start held while busy, with changed inputs
      @(negedge clk);
      start = 1'b1; mode = 4'd2; pc = AW'(8'h30); idx_x = '0;
      @(negedge clk);
      mode = 4'd1; pc = AW'(8'h50);
      check(!done, "R11 busy cycle 1", int'(done), 0);
      @(negedge clk);
      start = 1'b0;
      check(!done, "R11 busy start ignored", int'(done), 0);
      @(negedge clk);
      check(done == 1'b1, "R11 done of first op", int'(done), 1);
      check(int'(eff_addr) == memf(8'h31), "R11 captured address", int'(eff_addr), memf(8'h31));
      check(opnd_len == 2'd1, "R11 captured length", int'(opnd_len), 1);
      @(negedge clk);
      check(!done, "R11 no extra done", int'(done), 0);
      repeat (3) @(negedge clk);
      check(!done && !rd_en, "R11 quiet after op", int'({done, rd_en}), 0);

      finish_run();
   end

endmodule